// File: doc/BRIEF.md
# Two-segment ratio clock divider

This block produces a divided clock from a 96 MHz source. A 16-bit control register holds a 6-bit ratio field. The ratio field is translated into an integer divisor between 2 and 96 by a two-slope mapping. Small field values step the divisor by one, so divisors 2 through 8 are available. Larger field values step it by two, so only even divisors from 10 to 96 are reachable.

A cycle counter running on the source clock shapes the output waveform. The high phase lasts floor(d/2) source cycles and the low phase lasts the rest of the period. A new ratio is adopted only when the running period ends, so the output never shows a shortened pulse.

The output runs only when two conditions hold: bit 0 of the control register is zero, which selects the 96 MHz path, and the request input is high. Otherwise the output is held low and the counter restarts. The divisor currently in force is presented on a port.

Top module: `extclk_div`

## Requirements
- R1: After reset, rd_data equals the parameter RESET_VAL (default 16'hC30B: bit 0 = 1, bit 1 = 1, ratio field = 2, bits [15:8] = 8'hC3), clk_out is low and divisor reads 4.
- R2: A write (wr_en high at a clock edge) loads bits [7:2] of wr_data into the ratio field and clears bit 0. Bit 1 and bits [15:8] keep their previous values. The new value shows on rd_data after that edge.
- R3: Ratio field values 0 through 6 give a divisor equal to the field plus 2.
- R4: Ratio field values 7 through 50 give a divisor of 2*field - 4, which is always even (10 to 96).
- R5: Ratio field values 51 through 63 give divisor 96.
- R6: With divisor d running, clk_out is high for floor(d/2) consecutive source cycles and low for d - floor(d/2) cycles in every period.
- R7: A ratio written in the middle of a period does not change the divisor port or that period's length. The new divisor applies from the next period.
- R8: While clk_req is low, clk_out stays low. After clk_req rises, clk_out goes high at the next edge and stays high for a full floor(d/2) cycles.
- R9: While control bit 0 is 1, clk_out stays low even with clk_req high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 96 MHz source clock; also clocks the register |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Current control register value |
| clk_req | input | 1 | Clock request; low holds the output low |
| clk_out | output | 1 | Divided clock |
| divisor | output | 7 | Divisor currently in force |

## Verification
A wrong decode shows on the divisor port one period after the write and as a wrong high or low count in the very next full period. A counter that wraps at the wrong value gives a period length off by one, which is visible within one period. An early adoption of a new ratio shortens the period in which the write happens. A gating fault appears as a clk_out pulse within one cycle of clk_req dropping, or as a clk_out pulse before the first write while control bit 0 is set.

// File: rtl/extclk_pkg.sv
package extclk_pkg;

  // Two-slope ratio decode: unit steps up to the knee, double steps above,
  // saturated at the maximum divisor.
  function automatic int unsigned ratio_to_div(input int unsigned field,
                                               input int unsigned knee,
                                               input int unsigned max_div);
    int unsigned d;
    if (field <= knee) d = field + 2;
    else               d = (knee + 2) + 2 * (field - knee);
    if (d > max_div) d = max_div;
    return d;
  endfunction

  // Length of the high phase for a given divisor.
  function automatic int unsigned high_len(input int unsigned d);
    return d / 2;
  endfunction

endpackage

// File: rtl/extclk_ctrl_reg.sv
module extclk_ctrl_reg #(
  parameter int unsigned REG_W     = 16,
  parameter int unsigned RATIO_LSB = 2,
  parameter int unsigned RATIO_W   = 6,
  parameter logic [REG_W-1:0] RESET_VAL = 16'hC30B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctl,
  output logic [RATIO_W-1:0] ratio,
  output logic             src_sel_off
);
  localparam logic [REG_W-1:0] FIELD_MASK =
    REG_W'(((1 << RATIO_W) - 1) << RATIO_LSB);
  localparam logic [REG_W-1:0] SEL_MASK = REG_W'(1);

  logic [REG_W-1:0] ctl_next;

  always_comb begin
    ctl_next = (ctl & ~FIELD_MASK & ~SEL_MASK) | (wr_data & FIELD_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl <= RESET_VAL;
    else if (wr_en) ctl <= ctl_next;
  end

  assign ratio       = ctl[RATIO_LSB +: RATIO_W];
  assign src_sel_off = ctl[0];

  // R2: untouched bits survive a write, bit 0 ends cleared
  a_r2_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctl[1] == $past(ctl[1])) && (ctl[REG_W-1:8] == $past(ctl[REG_W-1:8]))
              && !ctl[0]);

endmodule

// File: rtl/extclk_ratio_decode.sv
module extclk_ratio_decode
  import extclk_pkg::*;
#(
  parameter int unsigned RATIO_W = 6,
  parameter int unsigned KNEE    = 6,
  parameter int unsigned MAX_DIV = 96,
  parameter int unsigned DIV_W   = $clog2(MAX_DIV + 1)
) (
  input  logic [RATIO_W-1:0] ratio,
  output logic [DIV_W-1:0]   div
);
  always_comb begin
    div = DIV_W'(ratio_to_div(int'(ratio), KNEE, MAX_DIV));
  end

  always_comb begin
    // R5: decoded divisor always within the legal range
    a_r5_div_range: assert (div >= DIV_W'(2) && div <= DIV_W'(MAX_DIV));
    // R4: upper segment produces only even divisors
    a_r4_even_upper: assert (int'(ratio) <= KNEE || div[0] == 1'b0);
  end

endmodule

// File: rtl/extclk_gen.sv
module extclk_gen
  import extclk_pkg::*;
#(
  parameter int unsigned DIV_W  = 7,
  parameter int unsigned RST_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] new_div,
  output logic [DIV_W-1:0] act_div,
  output logic             clk_out
);
  logic [DIV_W-1:0] cnt;
  logic             en_q;
  logic [DIV_W-1:0] half;
  logic             period_end;

  assign half       = DIV_W'(high_len(int'(act_div)));
  assign period_end = en_q && (cnt == act_div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cnt     <= '0;
      act_div <= DIV_W'(RST_DIV);
    end else if (!run) begin
      en_q    <= 1'b0;
      cnt     <= '0;
      act_div <= new_div;
    end else begin
      en_q <= 1'b1;
      if (period_end) begin
        cnt     <= '0;
        act_div <= new_div;
      end else if (en_q) begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  assign clk_out = en_q && (cnt < half);

  // R6: counter never leaves the current period
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < act_div);
  // R7: divisor only changes at a period boundary or while idle
  a_r7_hold_div: assert property (@(posedge clk) disable iff (!rst_n)
    (run && en_q && !period_end) |=> $stable(act_div));
  // R8: idle forces the output low on the next edge
  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !clk_out);

endmodule

// File: rtl/extclk_div.sv
module extclk_div
  import extclk_pkg::*;
#(
  parameter int unsigned REG_W     = 16,
  parameter int unsigned RATIO_LSB = 2,
  parameter int unsigned RATIO_W   = 6,
  parameter int unsigned KNEE      = 6,
  parameter int unsigned MAX_DIV   = 96,
  parameter logic [15:0] RESET_VAL = 16'hC30B,
  localparam int unsigned DIV_W    = $clog2(MAX_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             clk_req,
  output logic             clk_out,
  output logic [DIV_W-1:0] divisor
);
  localparam int unsigned RST_DIV =
    ratio_to_div(int'(RESET_VAL[RATIO_LSB +: RATIO_W]), KNEE, MAX_DIV);

  logic [RATIO_W-1:0] ratio;
  logic               src_sel_off;
  logic [DIV_W-1:0]   new_div;
  logic               run;

  extclk_ctrl_reg #(
    .REG_W(REG_W), .RATIO_LSB(RATIO_LSB), .RATIO_W(RATIO_W),
    .RESET_VAL(REG_W'(RESET_VAL))
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctl(rd_data), .ratio(ratio), .src_sel_off(src_sel_off)
  );

  extclk_ratio_decode #(
    .RATIO_W(RATIO_W), .KNEE(KNEE), .MAX_DIV(MAX_DIV), .DIV_W(DIV_W)
  ) u_dec (
    .ratio(ratio), .div(new_div)
  );

  assign run = clk_req && !src_sel_off;

  extclk_gen #(
    .DIV_W(DIV_W), .RST_DIV(RST_DIV)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .new_div(new_div),
    .act_div(divisor), .clk_out(clk_out)
  );

  // R2: written ratio field appears on the read port
  a_r2_write_field: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[RATIO_LSB +: RATIO_W] == $past(wr_data[RATIO_LSB +: RATIO_W]));
  // R9: source not selected keeps the output low
  a_r9_sel_low: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel_off |=> !clk_out);

endmodule

// File: tb/test_extclk_div.sv
`timescale 1ns/1ps
module test_extclk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        clk_req = 1'b0;
  logic        clk_out;
  logic [6:0]  divisor;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow;

  always #5 clk = ~clk;

  extclk_div i_extclk_div (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_req(clk_req), .clk_out(clk_out), .divisor(divisor)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Walk the list of reachable divisors: 2..8 then even values up to 96.
  function automatic int exp_div(input int f);
    int d = 2;
    for (int k = 0; k < f; k++) begin
      if (d >= 96) break;
      d += (d < 8) ? 1 : 2;
    end
    return d;
  endfunction

  task automatic write_ratio(input int f, input logic [15:0] other);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = (other & 16'hFF03) | 16'(f << 2);
    @(negedge clk);
    wr_en = 1'b0;
    shadow = {shadow[15:8], 6'(f), shadow[1], 1'b0};
  endtask

  // Wait for a rising output at a falling edge, then count one period.
  task automatic measure(output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    @(negedge clk);
    while (clk_out && guard < 400) begin @(negedge clk); guard++; end
    while (!clk_out && guard < 400) begin @(negedge clk); guard++; end
    while (clk_out && guard < 600) begin hi++; @(negedge clk); guard++; end
    while (!clk_out && guard < 800) begin lo++; @(negedge clk); guard++; end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 rd_data", int'(rd_data), 16'hC30B);
    check("R1 clk_out", int'(clk_out), 0);
    check("R1 divisor", int'(divisor), 4);
    shadow = rd_data;
  endtask

  task automatic t_sel_off();
    int seen = 0;
    clk_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (clk_out) seen++;
    end
    check("R9 no pulse while bit0 set", seen, 0);
  endtask

  task automatic t_write();
    write_ratio(5, 16'h00FC);
    check("R2 rd_data after write", int'(rd_data), int'(shadow));
    check("R2 bit0 cleared", int'(rd_data[0]), 0);
    check("R2 upper kept", int'(rd_data[15:8]), 16'hC3);
    check("R2 bit1 kept", int'(rd_data[1]), 1);
  endtask

  task automatic t_ratio(input int f, input string req);
    int hi, lo, d;
    d = exp_div(f);
    write_ratio(f, 16'h0000);
    measure(hi, lo);
    measure(hi, lo);
    check({req, " divisor"}, int'(divisor), d);
    check({req, " R6 high"}, hi, d / 2);
    check({req, " R6 low"}, lo, d - d / 2);
  endtask

  task automatic t_midchange();
    int hi = 0, lo = 0, guard = 0, div_mid;
    write_ratio(7, 16'h0000);
    measure(hi, lo);
    // align on a fresh rising output
    @(negedge clk);
    while (clk_out && guard < 400) begin @(negedge clk); guard++; end
    while (!clk_out && guard < 400) begin @(negedge clk); guard++; end
    hi = 0; lo = 0;
    while (clk_out && guard < 600) begin
      hi++;
      wr_en = (hi == 2);
      wr_data = 16'h0000;
      @(negedge clk); guard++;
    end
    wr_en = 1'b0;
    div_mid = int'(divisor);
    while (!clk_out && guard < 800) begin lo++; @(negedge clk); guard++; end
    shadow = {shadow[15:8], 6'd0, shadow[1], 1'b0};
    check("R7 divisor during old period", div_mid, 10);
    check("R7 old period high", hi, 5);
    check("R7 old period low", lo, 5);
    measure(hi, lo);
    check("R7 new period high", hi, 1);
    check("R7 new period low", lo, 1);
    check("R7 new divisor", int'(divisor), 2);
  endtask

  task automatic t_request();
    int seen = 0, hi = 0, guard = 0;
    write_ratio(6, 16'h0000);
    @(negedge clk);
    clk_req = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 15; i++) begin
      if (clk_out) seen++;
      @(negedge clk);
    end
    check("R8 low while request off", seen, 0);
    clk_req = 1'b1;
    @(negedge clk);
    check("R8 high right after request", int'(clk_out), 1);
    while (clk_out && guard < 50) begin hi++; @(negedge clk); guard++; end
    check("R8 full first high phase", hi, 4);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sel_off();
    t_write();
    t_ratio(0, "R3 f0");
    t_ratio(1, "R3 f1");
    t_ratio(5, "R3 f5");
    t_ratio(6, "R3 f6");
    t_ratio(7, "R4 f7");
    t_ratio(20, "R4 f20");
    t_ratio(50, "R4 f50");
    t_ratio(51, "R5 f51");
    t_ratio(63, "R5 f63");
    t_midchange();
    t_request();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule